// File: doc/BRIEF.md
# Prescaled Compare Timer Channel

This block is one channel of a general-purpose timer. A qualifying tick arrives on `tickEn`, which stands in for whatever clock source the channel has selected. An 8-bit prescaler divides the ticks down, and every prescaled tick advances a 24-bit up-counter. The counter is compared against a programmable value. On a match the counter returns to zero on the same tick and a sticky timeout flag is raised.

Three modes decide what happens after a match:
- **One-shot**: the channel disarms itself.
- **Periodic**: the channel keeps running and flags every match.
- **Toggle**: the channel also flips an output pin on every match.

Software works the channel through a small word-addressed register port. It can write the control, prescale and compare values, read back the live count at any time, and clear the flag by writing a one. An interrupt request follows the flag, gated by an enable bit.

Top module: `timer_channel`

## Requirements
- R1: The prescale register (address 1, bits 7:0) sets P. The counter advances once per P+1 qualifying ticks, so P=0 advances it on every tick. If P is lowered below the prescaler's current position, the next qualifying tick is a terminal one.
- R2: A read of address 3 returns the live 24-bit count in bits 23:0 at any time.
- R3: The compare register is at address 2, bits 23:0, and holds C. When a prescaled tick would take the count to C, the count becomes 0 on that tick instead and a match occurs. Matches therefore come every C prescaled ticks.
- R4: One-shot mode is mode code 0. On a match the hardware clears the enable bit (address 0, bit 0) and counting stops until software sets enable again. If software writes address 0 in the same cycle as the match, the written value wins.
- R5: Periodic mode is mode code 1, and code 3 behaves the same. The channel keeps counting through matches. Every match sets the timeout flag (address 4, bit 0). Writing 1 to that bit clears the flag, and writing 0 has no effect. If a match and a clear fall in the same cycle, the flag ends up set.
- R6: Toggle mode is mode code 2, held in address 0, bits 2:1. The `toggleOut` output flips on every match in this mode and keeps its level in the other modes.
- R7: `irq` is high exactly while the timeout flag is set and the interrupt-enable bit (address 0, bit 3) is 1.
- R8: While the enable bit is 0, or while `tickEn` is low, the prescaler and the counter hold their values.
- R9: Writing address 0 with bit 4 set zeroes the prescaler and the counter at that write, regardless of the other fields. Bit 4 always reads as 0.
- R10: After reset the following are all zero: the count, the prescaler, the flag, the control fields, the prescale and compare values, `irq` and `toggleOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Qualifying tick from the selected clock source |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 24 | Write data |
| rdata | output | 24 | Read data for `addr` |
| irq | output | 1 | Interrupt request |
| toggleOut | output | 1 | Toggle-mode output pin |

## Verification
Two collisions can fall in the same cycle:
- A match that sets the timeout flag and a software write of 1 that clears it.
- A one-shot match that clears the enable bit and a software write to the control register.

The first collision is provoked by setting C=2 with P=0 and a tick on every cycle, then issuing a clear on each of ten consecutive cycles. Every second clear then lands on a match. The cycle-accurate model in the bench applies set-over-clear and is compared on every clock against `irq` and against the flag read back at address 4. The second collision is handled by the register write taking priority over the hardware clear. The bench does not provoke it, and no check judges it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_PRESC  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMP    = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd4;

  // control word bit positions
  localparam int unsigned CTL_EN    = 0;
  localparam int unsigned CTL_MODE  = 1;
  localparam int unsigned CTL_IRQEN = 3;
  localparam int unsigned CTL_CLR   = 4;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_TOGGLE   = 2'd2,
    MODE_PERALT   = 2'd3
  } mode_e;

  typedef struct packed {
    logic run;   // qualifying tick while enabled
    logic zero;  // synchronous clear of prescaler and counter
  } dp_strobe_t;
endpackage

// File: rtl/timer_datapath.sv
module timer_datapath
  import tmr_pkg::*;
#(
  parameter int unsigned PS_W  = 8,
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_strobe_t       strobe,
  input  logic [PS_W-1:0]  prescale,
  input  logic [CNT_W-1:0] compare,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  logic [PS_W-1:0]  psCnt;
  logic [CNT_W-1:0] nextCount;
  logic             psTerm;

  assign psTerm    = (psCnt >= prescale);
  assign nextCount = count + CNT_W'(1);
  assign hit       = strobe.run && !strobe.zero && psTerm && (nextCount == compare);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt <= '0;
      count <= '0;
    end else if (strobe.zero) begin
      psCnt <= '0;
      count <= '0;
    end else if (strobe.run) begin
      if (psTerm) begin
        psCnt <= '0;
        count <= (nextCount == compare) ? '0 : nextCount;
      end else begin
        psCnt <= psCnt + PS_W'(1);
      end
    end
  end

  // R3: a match leaves the count at zero
  a_r3_match_zero: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> (count == '0));

  // R8: no run and no clear means the state holds
  a_r8_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.zero) |=> ($stable(count) && $stable(psCnt)));

  // R9: the clear strobe zeroes prescaler and counter
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zero |=> (count == '0 && psCnt == '0));
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import tmr_pkg::*;
#(
  parameter int unsigned PS_W  = 8,
  parameter int unsigned CNT_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              hit,
  input  logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  rdata,
  output dp_strobe_t        strobe,
  output logic [PS_W-1:0]   prescale,
  output logic [CNT_W-1:0]  compare,
  output logic              irq,
  output logic              toggleOut
);
  logic  enable, irqEn, flag;
  mode_e mode;
  logic  ctrlWr, statWr;

  assign ctrlWr = wrEn && (addr == ADDR_CTRL);
  assign statWr = wrEn && (addr == ADDR_STATUS);

  assign strobe.run  = enable && tickEn;
  assign strobe.zero = ctrlWr && wdata[CTL_CLR];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable    <= 1'b0;
      irqEn     <= 1'b0;
      mode      <= MODE_ONESHOT;
      prescale  <= '0;
      compare   <= '0;
      flag      <= 1'b0;
      toggleOut <= 1'b0;
    end else begin
      if (ctrlWr) begin
        enable <= wdata[CTL_EN];
        irqEn  <= wdata[CTL_IRQEN];
        mode   <= mode_e'(wdata[CTL_MODE +: 2]);
      end else if (hit && mode == MODE_ONESHOT) begin
        enable <= 1'b0;
      end
      if (wrEn && addr == ADDR_PRESC) prescale <= wdata[PS_W-1:0];
      if (wrEn && addr == ADDR_CMP)   compare  <= wdata;
      if (hit)                        flag <= 1'b1;
      else if (statWr && wdata[0])    flag <= 1'b0;
      if (hit && mode == MODE_TOGGLE) toggleOut <= ~toggleOut;
    end
  end

  assign irq = flag && irqEn;

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_CTRL: begin
        rdata[CTL_EN]         = enable;
        rdata[CTL_MODE +: 2]  = mode;
        rdata[CTL_IRQEN]      = irqEn;
      end
      ADDR_PRESC:  rdata[PS_W-1:0] = prescale;
      ADDR_CMP:    rdata = compare;
      ADDR_COUNT:  rdata = count;
      ADDR_STATUS: rdata[0] = flag;
      default:     rdata = '0;
    endcase
  end

  // R5: every match leaves the flag set, even against a clear
  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> flag);

  // R4: a one-shot match disarms the channel unless software writes control
  a_r4_oneshot_stop: assert property (@(posedge clk) disable iff (!rstN)
    (hit && mode == MODE_ONESHOT && !ctrlWr) |=> !enable);

  // R6: toggle-mode match flips the pin
  a_r6_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (hit && mode == MODE_TOGGLE) |=> (toggleOut != $past(toggleOut)));

  // R6: without a toggle-mode match the pin holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(hit && mode == MODE_TOGGLE) |=> $stable(toggleOut));

  // R7: a request never appears without the flag
  a_r7_irq_flag: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> flag);
endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import tmr_pkg::*;
#(
  parameter int unsigned PS_W  = 8,
  parameter int unsigned CNT_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq,
  output logic              toggleOut
);
  dp_strobe_t       strobe;
  logic [PS_W-1:0]  prescale;
  logic [CNT_W-1:0] compare;
  logic [CNT_W-1:0] count;
  logic             hit;

  timer_ctrl #(.PS_W(PS_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .hit(hit), .count(count), .rdata(rdata),
    .strobe(strobe), .prescale(prescale), .compare(compare),
    .irq(irq), .toggleOut(toggleOut)
  );

  timer_datapath #(.PS_W(PS_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .prescale(prescale),
    .compare(compare), .count(count), .hit(hit)
  );
endmodule

// File: tb/timer_channel_tb.sv
module timer_channel_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd3;
  logic [23:0] wdata = '0;
  logic [23:0] rdata;
  logic        irq, toggleOut;

  int checks = 0;
  int fails = 0;
  int tickMode = 0; // 0 always, 1 random, 2 never
  bit done = 0;

  // behavioural reference state
  int mEn = 0, mMode = 0, mIrqEn = 0, mPs = 0, mPre = 0, mCmp = 0, mCnt = 0;
  int mFlag = 0, mTog = 0;

  timer_channel u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .toggleOut(toggleOut)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    case (tickMode)
      0: tickEn <= 1'b1;
      1: tickEn <= ($urandom % 3) != 0;
      default: tickEn <= 1'b0;
    endcase
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expRead(input int a);
    case (a)
      0: return mEn | (mMode << 1) | (mIrqEn << 3);
      1: return mPre;
      2: return mCmp;
      3: return mCnt;
      4: return mFlag;
      default: return 0;
    endcase
  endfunction

  // model update at each edge, comparison two time units later
  always @(posedge clk) begin
    bit w, hit, clr;
    int a, d, c;
    w = wrEn; a = addr; d = wdata; hit = 0;
    if (!rstN) begin
      mEn = 0; mMode = 0; mIrqEn = 0; mPs = 0; mPre = 0; mCmp = 0;
      mCnt = 0; mFlag = 0; mTog = 0;
    end else begin
      clr = w && a == 0 && d[4];
      if (clr) begin
        mPs = 0; mCnt = 0;
      end else if (mEn && tickEn) begin
        if (mPs >= mPre) begin
          mPs = 0;
          c = (mCnt + 1) & 24'hFFFFFF;
          if (c == mCmp) begin mCnt = 0; hit = 1; end
          else mCnt = c;
        end else mPs++;
      end
      if (hit) mFlag = 1;
      else if (w && a == 4 && d[0]) mFlag = 0;
      if (hit && mMode == 2) mTog ^= 1;
      if (w && a == 0) begin
        mEn = d[0]; mMode = (d >> 1) & 3; mIrqEn = d[3];
      end else if (hit && mMode == 0) mEn = 0;
      if (w && a == 1) mPre = d & 8'hFF;
      if (w && a == 2) mCmp = d;
    end
    #2;
    if (!rstN) begin
      check(rdata == 24'(expRead(a)), "R10 read", rdata, expRead(a));
      check(irq == 1'b0, "R10 irq", irq, 0);
      check(toggleOut == 1'b0, "R10 toggleOut", toggleOut, 0);
    end else begin
      begin
        string tg;
        case (addr)
          0: tg = "R4 ctrl read";
          1: tg = "R1 prescale read";
          2: tg = "R3 compare read";
          3: tg = "R2 count read";
          4: tg = "R5 flag read";
          default: tg = "R2 unmapped read";
        endcase
        check(rdata == 24'(expRead(addr)), tg, rdata, expRead(addr));
      end
      check(irq == 1'(mFlag & mIrqEn), "R7 irq", irq, mFlag & mIrqEn);
      check(toggleOut == 1'(mTog), "R6 toggleOut", toggleOut, mTog);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; addr = 3'(a); wdata = 24'(d);
    @(negedge clk);
    wrEn = 1'b0; addr = 3'd3; wdata = '0;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    addr = 3'(a);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(3);                         // R10 reset state
    rstN = 1'b1;
    idle(2);
    // R3 R5 R7 periodic, P=0, C=5
    wr(1, 0); wr(2, 5); wr(0, 'hB);
    idle(20);
    rd(4); idle(3);
    wr(4, 0); rd(4); idle(2);        // R5 write 0 no effect
    wr(4, 1); rd(4); idle(2);        // R5 clear
    // R5 collision: clear on every cycle with a match every second
    wr(2, 2);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); wrEn = 1'b1; addr = 3'd4; wdata = 24'd1;
    end
    @(negedge clk); wrEn = 1'b0; addr = 3'd4; wdata = '0;
    idle(3);
    // R1 prescaler with irregular ticks
    wr(1, 3); wr(2, 6); tickMode = 1;
    idle(80);
    wr(1, 1); idle(20);              // R1 lowering prescale mid-count
    // R8 freeze on disable and on no tick
    wr(0, 'hA); idle(10); rd(0); idle(2);
    wr(0, 'hB); tickMode = 2; idle(8); tickMode = 0;
    // R9 clear bit mid-count
    idle(5); wr(0, 'h1B); rd(3); idle(5); rd(0); idle(2);
    // R4 one-shot, C=4
    wr(1, 0); wr(2, 4); wr(0, 'h19);
    idle(10); rd(0); idle(3); rd(3); idle(3);
    // R6 toggle mode, C=3
    wr(2, 3); wr(0, 'h15); idle(20);
    // R3 boundary C=1, match on every tick
    wr(2, 1); idle(6);
    // R7 irq masked while flag set
    wr(0, 'h3); idle(10); rd(4); idle(3);
    // mixed stretch
    wr(1, 2); wr(2, 7); wr(0, 'h1D); tickMode = 1; rd(3);
    idle(150);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule